// File: doc/BRIEF.md
# Mid-Period Strobed Group Capture

This block takes in a bank of discrete data bits from a neighbouring board that runs from the same clock. The sender changes its data lines, its per-group load enables and a single valid strobe just after each rising edge. The strobe appears only when bits are to be stored. It lasts one clock period and has no fixed rate. Each data bit is already present one period before the strobe that stores it, and it is still present while the strobe is high.

The block samples every input on the falling edge, in the middle of the bit period. This gives about half a period of margin on each side, less the clock skew. It then registers those samples again on the rising edge, so all logic after that point uses one edge. A group of output registers loads its own data slice when the retimed strobe and that group's retimed enable are both high. Groups whose enable is low keep their value. A single pulse marks each cycle in which at least one group was updated.

Top module: `center_capture`

## Requirements
- R1: While rst_ni is low, every bit of grp_o and load_done_o is zero. Reset acts at once, without waiting for a clock edge.
- R2: data_i, en_i and stb_i are captured on the falling clock edge. A change to an input after that falling edge and before the next rising edge has no effect on what is stored.
- R3: If stb_i and en_i[g] are both high in the period that begins at rising edge k, group g takes the value that data_i held at the falling edge of that period. The new value appears at grp_o on rising edge k+2, which is one cycle later than a direct rising-edge capture.
- R4: A group whose en_i bit is low in a strobe period keeps its previous value.
- R5: Group g occupies bits data_i[g*GROUP_W +: GROUP_W] and grp_o[g*GROUP_W +: GROUP_W]. When several enables are high with one strobe, every selected group loads from its own slice on the same edge.
- R6: If stb_i is low, no group changes, whatever en_i holds.
- R7: If stb_i is high while en_i is all zero, no group changes and load_done_o stays low.
- R8: load_done_o is high for exactly the cycle after rising edge k+2 when the period starting at edge k carried stb_i with any en_i bit high. This is the same edge on which the updated groups appear. At all other times it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock shared with the sending board |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | N_GROUPS*GROUP_W | Discrete data bits, group g in slice g |
| en_i | input | N_GROUPS | Per-group load enable |
| stb_i | input | 1 | One-period valid strobe |
| grp_o | output | N_GROUPS*GROUP_W | Captured group registers |
| load_done_o | output | 1 | One-cycle pulse when any group was loaded |

## Verification
A retime stage that is missing or doubled makes each group load one cycle early or one cycle late. The scoreboard sees this as a mismatch on grp_o two edges after the strobe, and load_done_o moves out of line at the same edge. A sampler on the wrong edge picks up data that changed after mid-period, so the glitch test shows the wrong slice in that same cycle. A bad enable decode or slice index corrupts a neighbouring group, and the per-cycle comparison of every group catches it at the first strobe that uses that group.

// File: rtl/center_capture_pkg.sv
package center_capture_pkg;
  localparam int unsigned DEF_GROUPS  = 4;
  localparam int unsigned DEF_GROUP_W = 8;
endpackage

// File: rtl/cc_fall_sampler.sv
module cc_fall_sampler #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  // mid-period capture of the sender's rising-edge launch
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/cc_rise_retimer.sv
module cc_rise_retimer #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/cc_group_bank.sv
module cc_group_bank #(
  parameter int unsigned N_GROUPS = 4,
  parameter int unsigned GROUP_W  = 8,
  localparam int unsigned TOT_W   = N_GROUPS * GROUP_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [TOT_W-1:0]    data_i,
  input  logic [N_GROUPS-1:0] en_i,
  input  logic                stb_i,
  output logic [TOT_W-1:0]    grp_o,
  output logic                done_o
);
  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    logic [GROUP_W-1:0] grp_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                grp_q <= '0;
      else if (stb_i && en_i[g])  grp_q <= data_i[g*GROUP_W +: GROUP_W];
    end
    assign grp_o[g*GROUP_W +: GROUP_W] = grp_q;
  end

  // aligned with the group update edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_o <= 1'b0;
    else         done_o <= stb_i && (|en_i);
  end
endmodule

// File: rtl/center_capture.sv
module center_capture
  import center_capture_pkg::*;
#(
  parameter int unsigned N_GROUPS = DEF_GROUPS,
  parameter int unsigned GROUP_W  = DEF_GROUP_W,
  localparam int unsigned TOT_W   = N_GROUPS * GROUP_W,
  localparam int unsigned CAP_W   = TOT_W + N_GROUPS + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [TOT_W-1:0]    data_i,
  input  logic [N_GROUPS-1:0] en_i,
  input  logic                stb_i,
  output logic [TOT_W-1:0]    grp_o,
  output logic                load_done_o
);
  logic [CAP_W-1:0]    fall_q, rise_q;
  logic [TOT_W-1:0]    data_r;
  logic [N_GROUPS-1:0] en_r;
  logic                stb_r;

  cc_fall_sampler #(.WIDTH(CAP_W)) u_fall (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({stb_i, en_i, data_i}),
    .q_o   (fall_q)
  );

  cc_rise_retimer #(.WIDTH(CAP_W)) u_rise (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (fall_q),
    .q_o   (rise_q)
  );

  assign {stb_r, en_r, data_r} = rise_q;

  cc_group_bank #(.N_GROUPS(N_GROUPS), .GROUP_W(GROUP_W)) u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .data_i(data_r),
    .en_i  (en_r),
    .stb_i (stb_r),
    .grp_o (grp_o),
    .done_o(load_done_o)
  );
endmodule

// File: rtl/center_capture_chk.sv
module center_capture_chk #(
  parameter int unsigned N_GROUPS = 4,
  parameter int unsigned GROUP_W  = 8,
  localparam int unsigned TOT_W   = N_GROUPS * GROUP_W
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [TOT_W-1:0]    data_i,
  input logic [N_GROUPS-1:0] en_i,
  input logic                stb_i,
  input logic [TOT_W-1:0]    grp_o,
  input logic                load_done_o
);
  // edges since reset release, saturating; gates $past lookback
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (grp_o == '0) && !load_done_o); // R1

  AST_DONE_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) && $past(stb_i && (|en_i), 2) |-> load_done_o); // R8

  AST_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) && !$past(stb_i && (|en_i), 2) |-> !load_done_o); // R7

  AST_NO_STROBE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) && !$past(stb_i, 2) |-> $stable(grp_o)); // R6

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_chk
    AST_GROUP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q == 2'd3) && !$past(stb_i && en_i[g], 2)
      |-> $stable(grp_o[g*GROUP_W +: GROUP_W])); // R4
  end
endmodule

bind center_capture center_capture_chk #(
  .N_GROUPS(N_GROUPS),
  .GROUP_W (GROUP_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .data_i     (data_i),
  .en_i       (en_i),
  .stb_i      (stb_i),
  .grp_o      (grp_o),
  .load_done_o(load_done_o)
);

// File: tb/center_capture_tb_top.sv
`timescale 1ns/1ps
module center_capture_tb_top;
  localparam int N  = 4;
  localparam int W  = 8;
  localparam int TW = N * W;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [TW-1:0] data_i = '0;
  logic [N-1:0]  en_i = '0;
  logic          stb_i = 1'b0;
  logic [TW-1:0] grp_o;
  logic          load_done_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  logic [TW-1:0] model = '0;
  int            due_q[$];
  logic [TW-1:0] grp_q[$];
  bit            done_q[$];
  string         tag_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  center_capture #(.N_GROUPS(N), .GROUP_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .en_i(en_i),
    .stb_i(stb_i), .grp_o(grp_o), .load_done_o(load_done_o)
  );

  task automatic check(input string tag, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // driver: launch one period of stimulus, push expectation for edge +2
  task automatic drive(input bit stb, input logic [N-1:0] en, input logic [TW-1:0] d,
                       input string tag, input bit glitch);
    @(posedge clk);
    #1;
    stb_i = stb; en_i = en; data_i = d;
    if (stb)
      for (int g = 0; g < N; g++)
        if (en[g]) model[g*W +: W] = d[g*W +: W];
    due_q.push_back(cyc + 2);
    grp_q.push_back(model);
    done_q.push_back(stb && (|en));
    tag_q.push_back(tag);
    if (glitch) begin
      #6;  // past the falling edge, before the next rising edge
      data_i = ~d;
    end
  endtask

  // monitor
  always @(posedge clk) begin
    #3;
    if (due_q.size() > 0 && due_q[0] == cyc) begin
      check($sformatf("%s grp", tag_q[0]), grp_o, grp_q[0]);
      check("R8 load_done", {{(TW-1){1'b0}}, load_done_o}, {{(TW-1){1'b0}}, done_q[0]});
      void'(due_q.pop_front()); void'(grp_q.pop_front());
      void'(done_q.pop_front()); void'(tag_q.pop_front());
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R3 watchdog act=timeout exp=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset grp", grp_o, '0);
    check("R1 reset done", {{(TW-1){1'b0}}, load_done_o}, '0);
    @(posedge clk); #1; rst_ni = 1'b1;

    // R3: data one tick ahead of strobe, then single group loads
    for (int g = 0; g < N; g++) begin
      drive(1'b0, '0, TW'(32'hA5A5_A5A5) ^ TW'(g), "R3 pre-data", 1'b0);
      drive(1'b1, N'(1) << g, {N{8'(8'h10 + g)}}, "R3 single load", 1'b0);
      drive(1'b0, '0, '0, "R4 idle", 1'b0);
    end
    // R6: enables without strobe
    drive(1'b0, '1, TW'(32'hDEAD_BEEF), "R6 en no stb", 1'b0);
    drive(1'b0, '1, TW'(32'hDEAD_BEEF), "R6 en no stb", 1'b0);
    // R7: strobe without enables
    drive(1'b1, '0, TW'(32'hCAFE_F00D), "R7 stb no en", 1'b0);
    drive(1'b0, '0, '0, "R7 idle", 1'b0);
    // R5: all groups at once, each from its own slice
    drive(1'b1, '1, TW'(32'h4433_2211), "R5 all groups", 1'b0);
    drive(1'b0, '0, '0, "R5 idle", 1'b0);
    // R4: partial enables
    drive(1'b1, N'(4'b0101), TW'(32'h9988_7766), "R4 partial", 1'b0);
    drive(1'b0, '0, '0, "R4 idle", 1'b0);
    // R2: data flips after the falling edge; stored value must be pre-flip
    drive(1'b1, '1, TW'(32'h1234_5678), "R2 late change", 1'b1);
    drive(1'b0, '0, '0, "R2 idle", 1'b0);
    drive(1'b1, N'(4'b1010), TW'(32'h0F0F_F0F0), "R2 late change", 1'b1);
    drive(1'b0, '0, '0, "R2 idle", 1'b0);

    // randomised strobes with gaps
    for (int i = 0; i < 400; i++) begin
      bit s;
      s = ($urandom_range(0, 3) == 0);
      drive(s, N'($urandom), TW'($urandom), s ? "R5 rand load" : "R6 rand gap", 1'b0);
      if (s) repeat ($urandom_range(0, 3)) drive(1'b0, N'($urandom), TW'($urandom), "R6 rand gap", 1'b0);
    end

    repeat (3) drive(1'b0, '0, '0, "R4 drain", 1'b0);
    @(posedge clk); #1;
    rst_ni = 1'b0;
    #1;
    check("R1 async reset grp", grp_o, '0);
    check("R1 async reset done", {{(TW-1){1'b0}}, load_done_o}, '0);

    finished = 1;
    summary();
    $finish;
  end
endmodule